// File: doc/BRIEF.md
# Minimum-Transition Test Vector Orderer

The block holds a small set of test vectors and finds the order in which to apply them so that the total number of input bit flips between consecutive vectors is as small as possible. Software or a neighbouring controller writes the vectors into numbered slots through a simple write port. It then pulses a start strobe. The block takes a snapshot of the pairwise Hamming distances into a register table. It then walks every ordering of the slots, one ordering per clock. For each ordering it adds up the distances between neighbours. The sequence is an open path: the last vector does not return to the first, which is the same as a closed tour through an extra node that is zero distance from every vector. The block keeps the cheapest ordering found so far.

The state machine has four states. `ST_IDLE` waits for the first strobe. `ST_DIST` is a single cycle that captures the distance table. `ST_SEARCH` evaluates one ordering per cycle. `ST_DONE` presents the result. The named transitions are:
- *go* (`ST_IDLE` to `ST_DIST` on start)
- *snap* (`ST_DIST` to `ST_SEARCH`, unconditional)
- *finish* (`ST_SEARCH` to `ST_DONE` after the last ordering)
- *again* (`ST_DONE` to `ST_DIST` on start)

In every other case the state holds.

Orderings are enumerated as a factorial-base counter decoded into a permutation. This visits the permutations in lexicographic order, and a strict less-than comparison keeps the first cheapest one.

Top module: `tos_orderer`

## Requirements
- R1: The cost between two vectors is the number of bit positions in which they differ; vectors that are all equal give a minimum cost of 0.
- R2: The cost of an ordering is the sum of the N-1 distances between consecutive vectors, with no return from the last vector to the first.
- R3: When done, `cost_o` equals the minimum ordering cost over all N! orderings of the loaded slots, and never exceeds (N-1)*W.
- R4: When done, `order_o` field i (bits [i*IDXW +: IDXW], IDXW = clog2(N)) holds the 0-based slot number of the vector applied i-th. Every slot appears exactly once.
- R5: Among orderings of equal minimum cost, the reported one is the first in lexicographic order of the slot sequence (field 0 most significant).
- R6: `done_o` rises exactly N!+1 clock edges after the edge at which start is accepted, and stays low in between.
- R7: A start strobe that arrives while a search is in progress (in `ST_DIST` or `ST_SEARCH`) has no effect on the timing or the result.
- R8: `done_o`, `cost_o` and `order_o` hold their values until the next start. `done_o` falls at the edge that accepts that start.
- R9: The distances are captured at the edge after start is accepted. Vector writes made after that edge do not alter the running search, but they do take effect at the next start.
- R10: After reset, `done_o`, `cost_o` and `order_o` are all zero.
- R11: A write with `load_en_i` high stores `load_data_i` into slot `load_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | Write enable for the vector slots |
| load_idx_i | input | IDXW | Slot number to write |
| load_data_i | input | W | Vector value to write |
| start_i | input | 1 | Start a search (accepted only when idle or done) |
| order_o | output | N*IDXW | Best ordering, field i = slot applied i-th |
| cost_o | output | CW | Total transitions of the best ordering |
| done_o | output | 1 | Result valid; held until the next start |

## Verification
The bound checker tests several properties on every cycle:
- The reported order is a true permutation whenever done is high.
- The cost stays within its bound.
- The result and done stay steady until a strobe arrives, and done drops on that strobe.
- Done stays low during a run, and it appears exactly N!+1 edges after the accepted strobe. This is tracked with a counter, which also shows that stray strobes during a run change nothing.

Only the bench scenarios can show that the reported cost is truly minimal, and that the lexicographically first tie wins. The same holds for showing that writes during a search leave the result alone and yet appear on the next run.

// File: rtl/tos_pkg.sv
package tos_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIST   = 2'd1,
        ST_SEARCH = 2'd2,
        ST_DONE   = 2'd3
    } tos_state_e;

    function automatic int tos_fact(input int n);
        int r;
        r = 1;
        for (int i = 2; i <= n; i++) begin
            r = r * i;
        end
        return r;
    endfunction

endpackage

// File: rtl/tos_dist_table.sv
module tos_dist_table #(
    parameter int N  = 4,
    parameter int W  = 7,
    parameter int DW = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cap_i,
    input  logic [N-1:0][W-1:0]            vec_i,
    output logic [N-1:0][N-1:0][DW-1:0]    dist_o
);

    logic [N-1:0][N-1:0][DW-1:0] pop_w;

    for (genvar a = 0; a < N; a++) begin : g_row
        for (genvar b = 0; b < N; b++) begin : g_col
            assign pop_w[a][b] = DW'($countones(vec_i[a] ^ vec_i[b]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dist_o <= '0;
        end else if (cap_i) begin
            dist_o <= pop_w;
        end
    end

endmodule

// File: rtl/tos_perm_decode.sv
module tos_perm_decode #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic [N-1:0][IDXW-1:0] digit_i,
    output logic [N-1:0][IDXW-1:0] perm_o
);

    always_comb begin
        logic [N-1:0]    taken;
        logic [IDXW-1:0] pick;
        logic            hit;
        int              rank;
        taken  = '0;
        perm_o = '0;
        for (int i = 0; i < N; i++) begin
            pick = '0;
            hit  = 1'b0;
            rank = 0;
            for (int j = 0; j < N; j++) begin
                if (!taken[j]) begin
                    if (!hit && rank == int'(digit_i[i])) begin
                        pick = IDXW'(j);
                        hit  = 1'b1;
                    end
                    rank = rank + 1;
                end
            end
            taken[pick] = 1'b1;
            perm_o[i]   = pick;
        end
    end

endmodule

// File: rtl/tos_path_cost.sv
module tos_path_cost #(
    parameter int N    = 4,
    parameter int IDXW = 2,
    parameter int DW   = 3,
    parameter int CW   = 5
) (
    input  logic [N-1:0][IDXW-1:0]        perm_i,
    input  logic [N-1:0][N-1:0][DW-1:0]   dist_i,
    output logic [CW-1:0]                 cost_o
);

    always_comb begin
        cost_o = '0;
        for (int i = 0; i < N - 1; i++) begin
            cost_o = cost_o + CW'(dist_i[perm_i[i]][perm_i[i+1]]);
        end
    end

endmodule

// File: rtl/tos_orderer.sv
module tos_orderer
    import tos_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 7,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1,
    localparam int DW   = $clog2(W + 1),
    localparam int CW   = $clog2((N - 1) * W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic [IDXW-1:0]   load_idx_i,
    input  logic [W-1:0]      load_data_i,
    input  logic              start_i,
    output logic [N*IDXW-1:0] order_o,
    output logic [CW-1:0]     cost_o,
    output logic              done_o
);

    tos_state_e state_q, state_nx;

    logic [N-1:0][W-1:0]          vec_q;
    logic [N-1:0][N-1:0][DW-1:0]  dist_w;
    logic [N-1:0][IDXW-1:0]       digit_q, digit_nx;
    logic [N-1:0][IDXW-1:0]       perm_w;
    logic [CW-1:0]                cur_cost_w;
    logic [N-1:0][IDXW-1:0]       best_order_q;
    logic [CW-1:0]                best_cost_q;
    logic                         first_q;
    logic                         last_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (load_en_i && int'(load_idx_i) < N) begin
            vec_q[load_idx_i] <= load_data_i;
        end
    end

    tos_dist_table #(.N(N), .W(W), .DW(DW)) u_dist (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (state_q == ST_DIST),
        .vec_i  (vec_q),
        .dist_o (dist_w)
    );

    tos_perm_decode #(.N(N), .IDXW(IDXW)) u_perm (
        .digit_i (digit_q),
        .perm_o  (perm_w)
    );

    tos_path_cost #(.N(N), .IDXW(IDXW), .DW(DW), .CW(CW)) u_cost (
        .perm_i (perm_w),
        .dist_i (dist_w),
        .cost_o (cur_cost_w)
    );

    // factorial-base counter: digit i has radix N-i, digit N-1 is always zero
    always_comb begin
        logic carry;
        carry    = 1'b1;
        digit_nx = digit_q;
        last_w   = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (digit_q[i] != IDXW'(N - 1 - i)) begin
                last_w = 1'b0;
            end
            if (carry) begin
                if (digit_q[i] == IDXW'(N - 1 - i)) begin
                    digit_nx[i] = '0;
                end else begin
                    digit_nx[i] = digit_q[i] + 1'b1;
                    carry       = 1'b0;
                end
            end
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_nx = ST_DIST;   // go
            ST_DIST:   state_nx = ST_SEARCH;              // snap
            ST_SEARCH: if (last_w) state_nx = ST_DONE;    // finish
            ST_DONE:   if (start_i) state_nx = ST_DIST;   // again
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            digit_q      <= '0;
            best_order_q <= '0;
            best_cost_q  <= '0;
            first_q      <= 1'b1;
        end else begin
            unique case (state_q)
                ST_DIST: begin
                    digit_q <= '0;
                    first_q <= 1'b1;
                end
                ST_SEARCH: begin
                    digit_q <= digit_nx;
                    first_q <= 1'b0;
                    if (first_q || cur_cost_w < best_cost_q) begin
                        best_cost_q  <= cur_cost_w;
                        best_order_q <= perm_w;
                    end
                end
                default: begin
                    digit_q <= digit_q;
                end
            endcase
        end
    end

    assign order_o = best_order_q;
    assign cost_o  = best_cost_q;
    assign done_o  = (state_q == ST_DONE);

endmodule

// File: rtl/tos_orderer_chk.sv
module tos_orderer_chk
    import tos_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 7,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1,
    localparam int CW   = $clog2((N - 1) * W + 1),
    localparam int LAT  = tos_fact(N) + 1,
    localparam int LCW  = $clog2(LAT + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [N*IDXW-1:0] order_o,
    input logic [CW-1:0]     cost_o,
    input logic              done_o
);

    logic [N-1:0]   seen;
    logic           run_q;
    logic [LCW-1:0] cnt_q;

    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(order_o[i*IDXW +: IDXW]) < N) begin
                seen[order_o[i*IDXW +: IDXW]] = 1'b1;
            end
        end
    end

    // independent run tracker: a strobe is taken only when no run is open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            if (start_i) begin
                run_q <= 1'b1;
                cnt_q <= LCW'(1);
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LCW'(LAT)) begin
                run_q <= 1'b0;
            end
        end
    end

    p_order_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&seen));

    p_cost_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(cost_o) <= (N - 1) * W));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(cost_o) && $stable(order_o)));

    p_done_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o);

    p_quiet_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !done_o);

    p_done_on_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> done_o);

endmodule

bind tos_orderer tos_orderer_chk #(.N(N), .W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .order_o (order_o),
    .cost_o  (cost_o),
    .done_o  (done_o)
);

// File: tb/tb_tos_orderer.sv
`timescale 1ns/1ps
module tb_tos_orderer;

    localparam int N     = 4;
    localparam int W     = 7;
    localparam int IDXW  = 2;
    localparam int CW    = 5;
    localparam int LAT   = 25;   // N! + 1
    localparam int NCASE = 5;

    // vector sets: slot 0 first
    localparam logic [W-1:0] CASE_VEC [NCASE][N] = '{
        '{7'b0000000, 7'b1111111, 7'b0001111, 7'b1110000},
        '{7'b1010101, 7'b1010101, 7'b1010101, 7'b1010101},
        '{7'b0000111, 7'b0000001, 7'b0001111, 7'b0000011},
        '{7'b0000001, 7'b0000010, 7'b0000100, 7'b0001000},
        '{7'b0000000, 7'b1111111, 7'b0000001, 7'b1111110}
    };
    localparam int CASE_COST [NCASE] = '{10, 0, 3, 6, 8};
    localparam int CASE_ORD  [NCASE][N] = '{
        '{0, 3, 1, 2},
        '{0, 1, 2, 3},
        '{1, 3, 0, 2},
        '{0, 1, 2, 3},
        '{0, 2, 1, 3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en_i = 1'b0;
    logic [IDXW-1:0]   load_idx_i = '0;
    logic [W-1:0]      load_data_i = '0;
    logic              start_i = 1'b0;
    logic [N*IDXW-1:0] order_o;
    logic [CW-1:0]     cost_o;
    logic              done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    tos_orderer #(.N(N), .W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en_i),
        .load_idx_i  (load_idx_i),
        .load_data_i (load_data_i),
        .start_i     (start_i),
        .order_o     (order_o),
        .cost_o      (cost_o),
        .done_o      (done_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    function automatic logic [N*IDXW-1:0] pack_ord(input int c);
        logic [N*IDXW-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            r[i*IDXW +: IDXW] = IDXW'(CASE_ORD[c][i]);
        end
        return r;
    endfunction

    task automatic load_set(input int c);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            load_en_i   = 1'b1;
            load_idx_i  = IDXW'(i);
            load_data_i = CASE_VEC[c][i];
        end
        @(negedge clk);
        load_en_i = 1'b0;
    endtask

    // pulse_at: edge count at which a stray strobe is driven (-1 none)
    // reload_c: case whose vectors are written during the search (-1 none)
    task automatic run_search(input int pulse_at, input int reload_c,
                              output int lat, output logic done_after);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        done_after = done_o;
        lat = 0;
        while (!done_o && lat < 200) begin
            start_i = (lat == pulse_at);
            if (reload_c >= 0 && lat >= 3 && lat < 3 + N) begin
                load_en_i   = 1'b1;
                load_idx_i  = IDXW'(lat - 3);
                load_data_i = CASE_VEC[reload_c][lat - 3];
            end else begin
                load_en_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i   = 1'b0;
        load_en_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        report();
        $finish;
    end

    initial begin
        int lat;
        logic dfall;
        logic [CW-1:0] c_hold;
        logic [N*IDXW-1:0] o_hold;

        repeat (3) @(negedge clk);
        // R10 reset state
        check(done_o === 1'b0, "R10 done after reset", int'(done_o), 0);
        check(cost_o === '0, "R10 cost after reset", int'(cost_o), 0);
        check(order_o === '0, "R10 order after reset", int'(order_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R6 R11
        for (int c = 0; c < NCASE; c++) begin
            load_set(c);
            run_search(-1, -1, lat, dfall);
            check(lat == LAT, $sformatf("R6 latency case %0d", c), lat, LAT);
            check(int'(cost_o) == CASE_COST[c],
                  $sformatf("R3 R1 R2 cost case %0d", c), int'(cost_o), CASE_COST[c]);
            check(order_o == pack_ord(c),
                  $sformatf("R4 R5 order case %0d", c), int'(order_o), int'(pack_ord(c)));
        end

        // R8 hold: result and done unchanged without a strobe
        c_hold = cost_o;
        o_hold = order_o;
        repeat (10) @(negedge clk);
        check(done_o === 1'b1, "R8 done held", int'(done_o), 1);
        check(cost_o == c_hold && order_o == o_hold, "R8 result held",
              int'(cost_o), int'(c_hold));

        // R7: stray strobe mid-search; R8 done falls on accepted start
        load_set(0);
        run_search(5, -1, lat, dfall);
        check(dfall === 1'b0, "R8 done falls on start", int'(dfall), 0);
        check(lat == LAT, "R7 latency with stray start", lat, LAT);
        check(int'(cost_o) == CASE_COST[0], "R7 cost with stray start",
              int'(cost_o), CASE_COST[0]);
        check(order_o == pack_ord(0), "R7 order with stray start",
              int'(order_o), int'(pack_ord(0)));

        // R9: writes during the search do not disturb it, but count next time
        run_search(-1, 3, lat, dfall);
        check(int'(cost_o) == CASE_COST[0], "R9 cost ignores mid-run writes",
              int'(cost_o), CASE_COST[0]);
        check(order_o == pack_ord(0), "R9 order ignores mid-run writes",
              int'(order_o), int'(pack_ord(0)));
        run_search(-1, -1, lat, dfall);
        check(int'(cost_o) == CASE_COST[3], "R9 R11 writes used on next start",
              int'(cost_o), CASE_COST[3]);
        check(order_o == pack_ord(3), "R9 order after next start",
              int'(order_o), int'(pack_ord(3)));

        report();
        $finish;
    end

endmodule